// File: doc/BRIEF.md
# Serial Two-Wire Register Target with Scratch RAM

This block is an I2C target. It lets an external host read and write a 64-byte register space over two wires. The first eight locations belong to the timekeeping logic next to it, which this block reaches through a small register-file port. The other 56 locations are a general-purpose RAM held inside the block. SCL and SDA are sampled by a much faster system clock. Each line passes through a synchroniser and a glitch filter. The block then recognises START, repeated START and STOP from the filtered lines.

A transfer opens with a START and an address byte. In a write, the next byte loads the word pointer and every byte after it is stored at the pointer. In a read, bytes come out MSB first, starting at the pointer. The pointer advances after every data byte in either direction. It wraps from the top of the space back to location zero. A host normally reads by first writing the pointer, then issuing a repeated START with the read bit set.

Top module: `i2c_regfile_target`

## Requirements
- R1: While reset is asserted and right after it, the block does not pull SDA (`sda_oe_o` = 0) and raises no timekeeping write strobe (`tk_we_o` = 0).
- R2: A START (SDA falling while SCL is high) begins address reception. A second START before any STOP (a repeated START) also restarts address reception, and the stored pointer is kept.
- R3: In the first byte after a START, bits 7..1 are compared with `DEV_ADDR` (default 0x68) and bit 0 is the direction (1 = read). On a match the block pulls SDA low during the ninth SCL clock (ACK). On a mismatch it leaves SDA released and ignores the bus until the next START.
- R4: In a write, the second byte loads its low 6 bits into the word pointer. Every later byte is stored at the pointer and acknowledged.
- R5: Pointer values 0x00 to 0x07 map to the timekeeping port. A write there gives a one-cycle `tk_we_o` pulse, with `tk_addr_o` equal to pointer bits 2..0 and the byte on `tk_wdata_o`. Values 0x08 to 0x3F address the internal 56-byte RAM, whose contents read back unchanged.
- R6: The pointer increments after every data byte, in writes and in reads alike, and wraps from 0x3F to 0x00.
- R7: In a read, bytes are shifted out MSB first, starting at the pointer. SDA changes only after SCL has fallen. When the host answers a byte with NACK (SDA high in the ninth clock), the block releases SDA and drives nothing until the next START.
- R8: A STOP (SDA rising while SCL is high) ends the transfer, even in the middle of a byte. Bits clocked afterwards get no ACK and cause no write.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks (default 3) is neither counted as a clock edge nor taken as a bus condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| tk_addr_o | output | 3 | Timekeeping register index (pointer bits 2..0) |
| tk_wdata_o | output | 8 | Byte to write into the timekeeping register |
| tk_we_o | output | 1 | One-cycle write strobe for the timekeeping register |
| tk_rdata_i | input | 8 | Timekeeping register contents at `tk_addr_o`, read combinationally |

## Verification
The assertions assume the host obeys the bus rules. SDA changes only while SCL is low, except when the host deliberately creates a START or STOP. Each SCL phase also lasts longer than the synchroniser and filter delay, so a filtered edge never lands on the same cycle as the opposite line's change. The stimulus holds each quarter of an SCL period for 25 system clocks, which is far above that delay. Its deliberate glitches last 2 clocks, below the filter length, so they probe R9 without breaking these assumptions.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_bit;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   out_q, out_d;

  assign sync_bit = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {SYNC_STAGES{1'b1}};
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (sync_bit == out_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
      out_d = sync_bit;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign line_o = out_q;

  // R9
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> ($past(sync_bit) == out_q));
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;

  // R2
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));
endmodule

// File: rtl/i2c_tgt_ram.sv
module i2c_tgt_ram #(
  parameter int DEPTH = 56,
  parameter int AW    = 6,
  parameter int BASE  = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int IW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] off;
  logic [IW-1:0] idx;

  assign off = addr_i - AW'(BASE);
  assign idx = off[IW-1:0];

  always_ff @(posedge clk) begin
    if (we_i && (off < AW'(DEPTH))) mem[idx] <= wdata_i;
  end

  assign rdata_o = (off < AW'(DEPTH)) ? mem[idx] : 8'h00;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         PTR_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_i,
  input  logic [7:0]       rd_byte_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_en_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o
);
  tgt_state_e       state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [7:0]       sh_q, sh_d;
  logic [6:0]       tx_q, tx_d;
  logic [3:0]       cnt_q, cnt_d;
  logic             rw_q, rw_d;
  logic             nack_q, nack_d;
  logic             oe_q, oe_d;
  logic             we_q, we_d;
  logic [7:0]       wdat_q, wdat_d;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    cnt_d   = cnt_q;
    rw_d    = rw_q;
    nack_d  = nack_q;
    oe_d    = oe_q;
    we_d    = 1'b0;
    wdat_d  = wdat_q;
    if (stop_i) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise_i) begin
            sh_d  = {sh_q[6:0], sda_i};
            cnt_d = cnt_q + 1'b1;
          end
          if (scl_fall_i && cnt_q == 4'd8) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                rw_d    = sh_q[0];
                oe_d    = 1'b1;
                state_d = ST_ADDR_ACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_PTR) begin
              ptr_d   = sh_q[PTR_W-1:0];
              oe_d    = 1'b1;
              state_d = ST_PTR_ACK;
            end else begin
              we_d    = 1'b1;
              wdat_d  = sh_q;
              oe_d    = 1'b1;
              state_d = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            cnt_d = '0;
            if (rw_q) begin
              tx_d    = rd_byte_i[6:0];
              oe_d    = ~rd_byte_i[7];
              state_d = ST_RDATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_PTR;
            end
          end
        end
        ST_PTR_ACK: begin
          if (scl_fall_i) begin
            oe_d    = 1'b0;
            state_d = ST_WDATA;
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall_i) begin
            oe_d    = 1'b0;
            ptr_d   = ptr_q + 1'b1;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              oe_d    = 1'b0;
              ptr_d   = ptr_q + 1'b1;
              state_d = ST_RDATA_ACK;
            end else begin
              oe_d  = ~tx_q[6];
              tx_d  = {tx_q[5:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise_i) nack_d = sda_i;
          if (scl_fall_i) begin
            if (nack_q) begin
              state_d = ST_IDLE;
            end else begin
              tx_d    = rd_byte_i[6:0];
              oe_d    = ~rd_byte_i[7];
              cnt_d   = '0;
              state_d = ST_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      cnt_q   <= cnt_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      wdat_q  <= wdat_d;
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_en_o   = we_q;
  assign wr_data_o = wdat_q;
  assign sda_oe_o  = oe_q;

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !sda_oe_o);

  // R2
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !sda_oe_o);

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  // R7
  drive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (state_q inside {ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK, ST_RDATA}));
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter int         TK_REGS     = 8,
  parameter int         RAM_BYTES   = 56
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [2:0] tk_addr_o,
  output logic [7:0] tk_wdata_o,
  output logic       tk_we_o,
  input  logic [7:0] tk_rdata_i
);
  localparam int PTR_W = $clog2(TK_REGS + RAM_BYTES);
  localparam int TK_AW = $clog2(TK_REGS);

  logic             rst_meta_q, rst_sync_q;
  logic [1:0]       raw_lines, filt_lines;
  logic             start_w, stop_w, rise_w, fall_w;
  logic [PTR_W-1:0] ptr_w;
  logic             wr_en_w;
  logic [7:0]       wr_data_w, ram_rdata_w, rd_byte_w;
  logic             in_tk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_sync_q),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  i2c_bus_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .scl_i     (filt_lines[1]),
    .sda_i     (filt_lines[0]),
    .start_o   (start_w),
    .stop_o    (stop_w),
    .scl_rise_o(rise_w),
    .scl_fall_o(fall_w)
  );

  i2c_tgt_ctrl #(
    .DEV_ADDR(DEV_ADDR),
    .PTR_W   (PTR_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start_i   (start_w),
    .stop_i    (stop_w),
    .scl_rise_i(rise_w),
    .scl_fall_i(fall_w),
    .sda_i     (filt_lines[0]),
    .rd_byte_i (rd_byte_w),
    .ptr_o     (ptr_w),
    .wr_en_o   (wr_en_w),
    .wr_data_o (wr_data_w),
    .sda_oe_o  (sda_oe_o)
  );

  assign in_tk = (ptr_w < PTR_W'(TK_REGS));

  i2c_tgt_ram #(
    .DEPTH(RAM_BYTES),
    .AW   (PTR_W),
    .BASE (TK_REGS)
  ) u_ram (
    .clk    (clk),
    .we_i   (wr_en_w & ~in_tk),
    .addr_i (ptr_w),
    .wdata_i(wr_data_w),
    .rdata_o(ram_rdata_w)
  );

  assign rd_byte_w  = in_tk ? tk_rdata_i : ram_rdata_w;
  assign tk_addr_o  = 3'(ptr_w[TK_AW-1:0]);
  assign tk_wdata_o = wr_data_w;
  assign tk_we_o    = wr_en_w & in_tk;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_q |-> (!sda_oe_o && !tk_we_o));
endmodule

// File: tb/i2c_regfile_target_tb_top.sv
module i2c_regfile_target_tb_top;
  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_drv, sda_drv;
  logic       sda_oe;
  logic       sda_line;
  logic [2:0] tk_addr;
  logic [7:0] tk_wdata, tk_rdata;
  logic       tk_we;
  logic [7:0] tk_regs [8];

  int checks = 0;
  int bad    = 0;
  logic [10:0] exp_q [$];

  always #2 clk = ~clk;

  assign sda_line = sda_drv & ~sda_oe;

  i2c_regfile_target dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_drv),
    .sda_i     (sda_line),
    .sda_oe_o  (sda_oe),
    .tk_addr_o (tk_addr),
    .tk_wdata_o(tk_wdata),
    .tk_we_o   (tk_we),
    .tk_rdata_i(tk_rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) tk_regs[i] <= 8'h40 + 8'(i);
    end else if (tk_we) begin
      tk_regs[tk_addr] <= tk_wdata;
    end
  end
  assign tk_rdata = tk_regs[tk_addr];

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected timekeeping writes (R5)
  always @(negedge clk) begin
    if (rst_n && tk_we) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected write", {tk_addr, tk_wdata}, 11'h7ff);
      end else begin
        chk("R5 write", {tk_addr, tk_wdata}, exp_q.pop_front());
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b1; wq();
  endtask

  // mode 0 plain, 1 short SCL pulse in low phase, 2 short SDA dip in high phase
  task automatic send_bit(input logic b, input int mode);
    sda_drv = b; wq();
    if (mode == 1) begin
      scl_drv = 1'b1; repeat (2) @(negedge clk);
      scl_drv = 1'b0; wq();
    end
    scl_drv = 1'b1; wq();
    if (mode == 2) begin
      sda_drv = 1'b0; repeat (2) @(negedge clk);
      sda_drv = b;
    end
    wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1; wq();
    b = sda_line; wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack,
                         input int gbit = -1, input int mode = 0);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i], (i == gbit) ? mode : 0);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~ack, 0);
  endtask

  task automatic push_tk(input logic [2:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    logic       b;
    rst_n = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1;
    repeat (10) @(negedge clk);
    // R1 reset state
    chk("R1 oe", 11'(sda_oe), 11'h0);
    chk("R1 we", 11'(tk_we), 11'h0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 oe after reset", 11'(sda_oe), 11'h0);

    // R3 address mismatch: no ACK, later byte ignored
    i2c_start();
    wr_byte(8'hA0, ack); chk("R3 mismatch nack", 11'(ack), 11'h0);
    wr_byte(8'h12, ack); chk("R3 ignored byte", 11'(ack), 11'h0);
    i2c_stop();

    // R4 R5 write to timekeeping registers
    i2c_start();
    wr_byte(8'hD0, ack); chk("R3 match ack", 11'(ack), 11'h1);
    wr_byte(8'h02, ack); chk("R4 ptr ack", 11'(ack), 11'h1);
    push_tk(3'd2, 8'h11);
    wr_byte(8'h11, ack); chk("R4 data ack", 11'(ack), 11'h1);
    push_tk(3'd3, 8'h22);
    wr_byte(8'h22, ack); chk("R6 second data ack", 11'(ack), 11'h1);
    i2c_stop();
    chk("R5 writes seen", 11'(exp_q.size()), 11'h0);

    // R6 wrap from RAM top into timekeeping space
    i2c_start();
    wr_byte(8'hD0, ack);
    wr_byte(8'h3E, ack);
    wr_byte(8'hA5, ack);
    wr_byte(8'h5A, ack);
    push_tk(3'd0, 8'hC3);
    wr_byte(8'hC3, ack);
    i2c_stop();
    chk("R6 wrap write", 11'(exp_q.size()), 11'h0);

    // R2 R7 repeated START read across the wrap, then NACK
    i2c_start();
    wr_byte(8'hD0, ack);
    wr_byte(8'h3E, ack);
    i2c_start();
    wr_byte(8'hD1, ack); chk("R2 restart ack", 11'(ack), 11'h1);
    rd_byte(d, 1'b1); chk("R7 ram 3E", 11'(d), 11'hA5);
    rd_byte(d, 1'b1); chk("R6 ram 3F", 11'(d), 11'h5A);
    rd_byte(d, 1'b1); chk("R6 wrapped to 00", 11'(d), 11'hC3);
    rd_byte(d, 1'b0); chk("R7 tk 01", 11'(d), 11'h41);
    for (int i = 0; i < 9; i++) begin
      recv_bit(b);
      chk("R7 released after nack", 11'(b), 11'h1);
    end
    i2c_stop();

    // R5 RAM mid-range write and read back
    i2c_start();
    wr_byte(8'hD0, ack);
    wr_byte(8'h10, ack);
    wr_byte(8'h77, ack);
    wr_byte(8'h88, ack);
    i2c_start();
    wr_byte(8'hD0, ack);
    wr_byte(8'h10, ack);
    i2c_start();
    wr_byte(8'hD1, ack);
    rd_byte(d, 1'b1); chk("R5 ram 10", 11'(d), 11'h77);
    rd_byte(d, 1'b0); chk("R5 ram 11", 11'(d), 11'h88);
    i2c_stop();

    // R8 STOP mid-byte aborts; following bits ignored
    i2c_start();
    wr_byte(8'hD0, ack);
    wr_byte(8'h05, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 0);
    i2c_stop();
    wr_byte(8'h99, ack); chk("R8 no ack after stop", 11'(ack), 11'h0);
    i2c_start();
    wr_byte(8'hD1, ack);
    rd_byte(d, 1'b0); chk("R8 tk 05 untouched", 11'(d), 11'h45);
    i2c_stop();

    // R9 short pulses on SCL and SDA are filtered out
    i2c_start();
    wr_byte(8'hD0, ack);
    wr_byte(8'h06, ack, 3, 1); chk("R9 scl glitch ack", 11'(ack), 11'h1);
    push_tk(3'd6, 8'h3C);
    wr_byte(8'h3C, ack, 5, 2); chk("R9 sda glitch ack", 11'(ack), 11'h1);
    i2c_stop();
    chk("R9 write landed", 11'(exp_q.size()), 11'h0);

    repeat (20) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule